// File: doc/BRIEF.md
# Buffered Baud Rate Generator

This block derives the two timing strobes a UART needs from the bus clock. One strobe is a receiver sample tick at sixteen times the baud rate. The other is a transmit bit tick at the baud rate. Both come from a 13-bit modulo divisor BR. Software loads BR through an 8-bit register port as two bytes. A write to the upper byte is only held in a staging buffer. A later write to the lower byte commits all 13 bits in a single cycle, so the divide chain never runs with a half-updated value. The upper-byte register also carries two interrupt-enable bits, which the block drives straight to its outputs for use by neighbouring logic.

A small controller with three states gates the divide chain:

- `GEN_IDLE`: neither the receiver nor the transmitter is enabled.
- `GEN_HALT`: at least one enable is set, but the divisor is zero.
- `GEN_RUN`: the counters advance.

The controller moves between states on these named transitions. Each one is evaluated at every clock edge against the divisor that will be in force after that edge.

- `wake`: IDLE to RUN.
- `wake_zero`: IDLE to HALT.
- `resume`: HALT to RUN.
- `zeroed`: RUN to HALT.
- `sleep`: RUN or HALT to IDLE.

Each commit of a new divisor restarts both counters. Leaving `GEN_RUN` clears them.

Top module: `baud_gen_top`

## Requirements
- R1: After reset, the low-byte register (`reg_sel`=1) reads 0x04, the high-byte register (`reg_sel`=0) reads 0x00, both interrupt enables are 0, and no tick is produced.
- R2: A write with `reg_sel`=0 stores the divisor's bits 12:8 from data bits 4:0 in a buffer only. Until the next low-byte write, the tick period and the high-byte read value of divisor bits 12:8 keep the previously committed value.
- R3: A write with `reg_sel`=1 commits BR = {buffered bits 12:8, written byte}. A read with `reg_sel`=1 returns the committed bits 7:0.
- R4: While running, `sample_tick` is a one-cycle pulse once every BR bus clocks.
- R5: `bit_tick` is a one-cycle pulse that coincides with every sixteenth `sample_tick`, giving one pulse per 16×BR bus clocks.
- R6: When the committed BR is 0, neither tick is produced.
- R7: No tick is produced while both `rx_en` and `tx_en` are 0. Either enable alone starts the generator. Dropping both stops the counters and clears them, so the next start begins a fresh period.
- R8: A commit restarts both counters. The first `sample_tick` after a commit appears in the BR-th cycle after the commit edge.
- R9: High-byte bit 7 is the break-detect interrupt enable (`brk_irq_en`) and bit 6 is the edge interrupt enable (`edge_irq_en`). Both are written and read back in those positions. Bit 5 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = high byte, 1 = low byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| rx_en | input | 1 | Receiver enable |
| tx_en | input | 1 | Transmitter enable |
| sample_tick | output | 1 | Sample strobe at 16× baud |
| bit_tick | output | 1 | Bit strobe at baud rate |
| brk_irq_en | output | 1 | Break-detect interrupt enable bit |
| edge_irq_en | output | 1 | Input-edge interrupt enable bit |

## Verification
The bench builds the block with its default parameters: a 13-bit divisor, an 8-bit register port and 16× oversampling. Divisors of 1, 3 and 4 make whole bit periods short enough to watch many `bit_tick` wraps. A divisor of 0x102 uses the high byte and checks a multi-thousand-cycle bit period. The zero divisor, single-enable and enable-drop cases reach `GEN_HALT` and the `sleep` transition. Commits made in mid-period check the counter restart.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
    typedef enum logic [1:0] {
        GEN_IDLE = 2'd0,
        GEN_HALT = 2'd1,
        GEN_RUN  = 2'd2
    } gen_state_e;
endpackage

// File: rtl/baud_regs.sv
module baud_regs #(
    parameter int DIV_W    = 13,
    parameter int DATA_W   = 8,
    parameter int RESET_LO = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DIV_W-1:0]  br_work,
    output logic [DIV_W-1:0]  br_next,
    output logic              commit,
    output logic              brk_ie,
    output logic              edge_ie
);
    localparam int HI_W  = DIV_W - DATA_W;
    localparam int PAD_W = DATA_W - 2 - HI_W;

    logic [HI_W-1:0] hi_buf;
    logic            hi_wr;

    assign commit  = wr && sel;
    assign hi_wr   = wr && !sel;
    assign br_next = commit ? {hi_buf, wdata} : br_work;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_buf  <= '0;
            brk_ie  <= 1'b0;
            edge_ie <= 1'b0;
        end else if (hi_wr) begin
            hi_buf  <= wdata[HI_W-1:0];
            brk_ie  <= wdata[DATA_W-1];
            edge_ie <= wdata[DATA_W-2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            br_work <= DIV_W'(RESET_LO);
        end else begin
            br_work <= br_next;
        end
    end

    always_comb begin
        if (sel) begin
            rdata = br_work[DATA_W-1:0];
        end else begin
            rdata = {brk_ie, edge_ie, {PAD_W{1'b0}}, br_work[DIV_W-1:DATA_W]};
        end
    end

    // R2: a high-byte write alone never disturbs the working divisor
    p_hi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> $stable(br_work));
endmodule

// File: rtl/baud_ctrl.sv
module baud_ctrl
    import baud_gen_pkg::*;
#(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             tx_en,
    input  logic [DIV_W-1:0] br_next,
    output logic             run,
    output logic             run_next
);
    gen_state_e state_q, state_d;
    logic       any_en;
    logic       div_ok;

    assign any_en = rx_en || tx_en;
    assign div_ok = (br_next != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GEN_IDLE: begin
                if (any_en && div_ok)       state_d = GEN_RUN;   // wake
                else if (any_en)            state_d = GEN_HALT;  // wake_zero
            end
            GEN_HALT: begin
                if (!any_en)                state_d = GEN_IDLE;  // sleep
                else if (div_ok)            state_d = GEN_RUN;   // resume
            end
            GEN_RUN: begin
                if (!any_en)                state_d = GEN_IDLE;  // sleep
                else if (!div_ok)           state_d = GEN_HALT;  // zeroed
            end
            default:                        state_d = GEN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GEN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        run      = (state_q == GEN_RUN);
        run_next = (state_d == GEN_RUN);
    end

    // R7: the idle state is left only when an enable is present
    p_idle_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GEN_IDLE && !any_en) |=> (state_q == GEN_IDLE));
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
    parameter int DIV_W = 13,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             run_next,
    input  logic             restart,
    input  logic [DIV_W-1:0] br_work,
    output logic             sample_tick,
    output logic             bit_tick
);
    localparam int              OVS_W   = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [DIV_W-1:0] ONE    = DIV_W'(1);
    localparam logic [OVS_W-1:0] OVS_TOP = OVS_W'(OVS - 1);

    logic [DIV_W-1:0] presc;
    logic [OVS_W-1:0] ovs;
    logic             presc_wrap;
    logic             clear;

    assign presc_wrap = (presc == br_work - ONE);
    assign clear      = restart || !run || !run_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc <= '0;
            ovs   <= '0;
        end else if (clear) begin
            presc <= '0;
            ovs   <= '0;
        end else if (presc_wrap) begin
            presc <= '0;
            ovs   <= (ovs == OVS_TOP) ? '0 : ovs + OVS_W'(1);
        end else begin
            presc <= presc + ONE;
        end
    end

    always_comb begin
        sample_tick = run && presc_wrap;
        bit_tick    = sample_tick && (ovs == OVS_TOP);
    end

    // R4: while running the prescaler stays below the committed divisor
    p_presc_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (presc < br_work));
endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top #(
    parameter int DIV_W    = 13,
    parameter int DATA_W   = 8,
    parameter int OVS      = 16,
    parameter int RESET_LO = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rx_en,
    input  logic              tx_en,
    output logic              sample_tick,
    output logic              bit_tick,
    output logic              brk_irq_en,
    output logic              edge_irq_en
);
    logic [DIV_W-1:0] br_work;
    logic [DIV_W-1:0] br_next;
    logic             commit;
    logic             run;
    logic             run_next;

    baud_regs #(.DIV_W(DIV_W), .DATA_W(DATA_W), .RESET_LO(RESET_LO)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .sel     (reg_sel),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .br_work (br_work),
        .br_next (br_next),
        .commit  (commit),
        .brk_ie  (brk_irq_en),
        .edge_ie (edge_irq_en)
    );

    baud_ctrl #(.DIV_W(DIV_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .tx_en    (tx_en),
        .br_next  (br_next),
        .run      (run),
        .run_next (run_next)
    );

    baud_divider #(.DIV_W(DIV_W), .OVS(OVS)) div_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .run_next    (run_next),
        .restart     (commit),
        .br_work     (br_work),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick)
    );

    // R6: a zero divisor yields no ticks
    p_zero_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (br_work == '0) |-> (!sample_tick && !bit_tick));

    // R7: with both enables low the next cycle carries no tick
    p_enable_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !tx_en) |=> !sample_tick);

    // R4: ticks are single-cycle unless the divisor is one
    p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && br_work != DIV_W'(1) && !commit) |=> !sample_tick);

    // R5: a bit tick never appears without a sample tick
    p_bit_in_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);
endmodule

// File: tb/baud_gen_top_tb_top.sv
`timescale 1ns/1ps
module baud_gen_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       rx_en = 1'b0;
    logic       tx_en = 1'b0;
    logic       sample_tick, bit_tick, brk_irq_en, edge_irq_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_buf = 0, m_br = 4, m_n = 0;
    bit m_run = 0, m_bk = 0, m_ed = 0;

    always #5 clk = ~clk;

    baud_gen_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_en(rx_en),
        .tx_en(tx_en), .sample_tick(sample_tick), .bit_tick(bit_tick),
        .brk_irq_en(brk_irq_en), .edge_irq_en(edge_irq_en)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // reference model, compared every clock
    always @(posedge clk) begin
        bit commit, nrun;
        int nbr;
        if (!rst_n) begin
            m_buf = 0; m_br = 4; m_n = 0; m_run = 0; m_bk = 0; m_ed = 0;
        end else begin
            commit = reg_wr && reg_sel;
            nbr    = commit ? ((m_buf << 8) | int'(reg_wdata)) : m_br;
            nrun   = (rx_en || tx_en) && (nbr != 0);
            if (nrun && m_run && !commit) m_n = (m_n + 1) % (16 * m_br);
            else                          m_n = 0;
            m_br  = nbr;
            m_run = nrun;
            if (reg_wr && !reg_sel) begin
                m_buf = int'(reg_wdata) & 31;
                m_bk  = reg_wdata[7];
                m_ed  = reg_wdata[6];
            end
        end
        #1;
        if (rst_n && !done) begin
            int exp_s, exp_b, exp_rd;
            exp_s  = (m_run && (m_n % m_br) == m_br - 1) ? 1 : 0;
            exp_b  = (m_run && m_n == 16 * m_br - 1) ? 1 : 0;
            exp_rd = reg_sel ? (m_br & 255)
                             : ((m_bk << 7) | (m_ed << 6) | ((m_br >> 8) & 31));
            chk("R4", int'(sample_tick), exp_s);
            chk("R5", int'(bit_tick), exp_b);
            chk(reg_sel ? "R3" : "R2", int'(reg_rdata), exp_rd);
            chk("R9", int'({brk_irq_en, edge_irq_en}), (m_bk << 1) | m_ed);
        end
    end

    task automatic wr_reg(bit sel, int data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = 8'(data);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_ticks(int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sample_tick || bit_tick) cnt++;
        end
    endtask

    // cycles from the commit edge to the first sample tick (called after wr_reg)
    task automatic latency(output int k);
        k = 1;
        while (!sample_tick && k < 20000) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int cnt, k;
        idle(3);
        rst_n = 1'b1;
        // R1: reset state
        reg_sel = 1'b1; #1;
        chk("R1", int'(reg_rdata), 4);
        reg_sel = 1'b0; #1;
        chk("R1", int'(reg_rdata), 0);
        chk("R1", int'({brk_irq_en, edge_irq_en}), 0);
        // R7: silent while both enables are low
        count_ticks(40, cnt);
        chk("R7", cnt, 0);

        // R4/R5 with the reset divisor 4, receiver only
        rx_en = 1'b1;
        idle(200);

        // R2/R9: buffered high byte with interrupt enables; bit 5 ignored
        wr_reg(1'b0, 8'hE1);
        reg_sel = 1'b0; #1;
        chk("R2", int'(reg_rdata), 8'hC0);
        chk("R9", int'({brk_irq_en, edge_irq_en}), 3);
        idle(70);

        // R3: commit 0x102, long period across many bits
        wr_reg(1'b1, 8'h02);
        reg_sel = 1'b1; #1;
        chk("R3", int'(reg_rdata), 8'h02);
        reg_sel = 1'b0; #1;
        chk("R9", int'(reg_rdata), 8'hC1);
        idle(9000);

        // R8: commit mid-period to divisor 3 and measure restart latency
        wr_reg(1'b0, 8'h00);
        idle(5);
        wr_reg(1'b1, 8'h03);
        latency(k);
        chk("R8", k, 3);
        idle(150);

        // divisor 1: tick every cycle, bit tick every 16
        wr_reg(1'b1, 8'h01);
        latency(k);
        chk("R8", k, 1);
        idle(100);

        // R7: transmitter alone keeps it running, dropping both stops it
        tx_en = 1'b1; rx_en = 1'b0;
        wr_reg(1'b1, 8'h04);
        idle(37);
        tx_en = 1'b0;
        @(negedge clk);
        count_ticks(50, cnt);
        chk("R7", cnt, 0);
        tx_en = 1'b1;
        @(negedge clk);
        latency(k);
        chk("R7", k, 4);
        idle(150);

        // R6: zero divisor silences the generator
        wr_reg(1'b1, 8'h00);
        count_ticks(100, cnt);
        chk("R6", cnt, 0);
        reg_sel = 1'b1; #1;
        chk("R6", int'(reg_rdata), 0);

        // R9: bit 5 ignored, interrupt enables cleared
        wr_reg(1'b0, 8'h20);
        wr_reg(1'b1, 8'h05);
        reg_sel = 1'b0; #1;
        chk("R9", int'(reg_rdata), 0);
        rx_en = 1'b1;
        idle(200);
        finish_run();
    end
endmodule